// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

A general-purpose I/O block with 28 pins behind a small 32-bit memory-mapped register port. Software picks each pin's direction and changes output levels only through two strobe registers: one raises pins, the other lowers them. Unmentioned pins are left alone, so no read-modify-write of the output state is needed. The current pin levels are read back after a two-flop synchroniser.

Each pin has its own rising-edge enable and falling-edge enable. A qualified edge latches a sticky status bit. Software clears that bit by writing a one to its position. The status drives eleven dedicated interrupt lines for pins 0 to 10 and one shared line for pins 11 to 27. A per-pin alternate-function bit is stored and exposed on a port for the pad multiplexer outside the block.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, the direction, output data, both edge enables, edge status and alternate-function registers are all zero. All interrupt outputs are low.
- R2: Registers are selected by address bits [4:2]:
  - 0 = pin level
  - 1 = direction
  - 2 = output set
  - 3 = output clear
  - 4 = rising enable
  - 5 = falling enable
  - 6 = edge status
  - 7 = alternate function

  Read data bits 31:28 are always zero. Reads of the set and clear registers return zero.
- R3: A direction bit of 1 enables the output driver of that pin on `pin_oe`, and 0 disables it.
- R4: Writing the set register drives `pin_out` high for every bit written as 1. Other bits are unchanged.
- R5: Writing the clear register drives `pin_out` low for every bit written as 1. Other bits are unchanged.
- R6: The level register returns `pin_in` delayed by two clocks. A change is not visible one clock after it is applied and is visible after two.
- R7: With its rising enable set, a 0-to-1 change on a pin sets its status bit on the third clock edge after the change. With neither enable set, no status bit is set.
- R8: With its falling enable set, a 1-to-0 change on a pin sets its status bit. With both enables set, either edge sets it. An edge of a disabled polarity is ignored.
- R9: A status bit stays set until a 1 is written to its position in the status register. Bits written as 0 stay pending.
- R10: When an edge and a clear of the same status bit land on the same clock edge, the bit remains set.
- R11: `irq_direct[i]` equals the status bit of pin i for pins 0 to 10.
- R12: `irq_shared` is high while any status bit of pins 11 to 27 is set.
- R13: The alternate-function register is read back and appears on `alt_func`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_out | output | 28 | Output data to pads |
| pin_oe | output | 28 | Output enable per pin |
| alt_func | output | 28 | Alternate-function selects |
| irq_direct | output | 11 | Interrupts for pins 0 to 10 |
| irq_shared | output | 1 | OR of status for pins 11 to 27 |

## Verification
The bench sweeps every pin through all four combinations of the edge enables with both edge polarities. This catches any pin whose enable bits are crossed, and a wrong split between the dedicated and shared interrupts: an off-by-one at pin 10 or 11 would raise the wrong line. It times a status clear to land on the same edge as a new rising edge. A design where the clear wins would drop the event and read zero. It also samples the level register one clock early to reject a missing synchroniser stage. Partial set, clear and status-clear writes show that zero bits really leave state untouched; a design treating the strobes as plain writes would lose the other pins.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   typedef enum logic [2:0] {
      REG_LEVEL = 3'd0,
      REG_DIR   = 3'd1,
      REG_SET   = 3'd2,
      REG_CLR   = 3'd3,
      REG_REN   = 3'd4,
      REG_FEN   = 3'd5,
      REG_STAT  = 3'd6,
      REG_ALT   = 3'd7
   } gpio_reg_e;

   function automatic gpio_reg_e reg_of(input logic [2:0] word_idx);
      return gpio_reg_e'(word_idx);
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 28,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] status
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] keep;

   always_comb begin
      hit  = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);
      keep = clr_we ? (status & ~clr_mask) : status;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= level;
         status <= keep | hit;   // a new edge outranks a clear
      end
   end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
   parameter int NUM_PINS    = 28,
   parameter int NUM_DIRECT  = 11,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [NUM_PINS-1:0]   alt_func,
   output logic [NUM_DIRECT-1:0] irq_direct,
   output logic                  irq_shared
);
   import gpio_edge_pkg::*;

   localparam int SHARED_N = NUM_PINS - NUM_DIRECT;

   initial begin
      assert (NUM_PINS <= DATA_W) else $fatal(1, "NUM_PINS exceeds DATA_W");
      assert (NUM_DIRECT >= 1 && SHARED_N >= 1) else $fatal(1, "bad interrupt split");
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES below 2");
      assert (ADDR_W >= 5) else $fatal(1, "ADDR_W below 5");
   end

   logic [NUM_PINS-1:0] dir_q, out_q, ren_q, fen_q, alt_q;
   logic [NUM_PINS-1:0] lvl_s, stat_q, wmask;
   logic                wr_en;
   gpio_reg_e           sel_reg;
   logic                unused_bits;

   assign unused_bits = ^{bus_wdata, bus_addr};
   assign wr_en   = bus_sel && bus_wr;
   assign sel_reg = reg_of(bus_addr[4:2]);
   assign wmask   = bus_wdata[NUM_PINS-1:0];

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl_s)
   );

   gpio_edge_det #(.WIDTH(NUM_PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .level(lvl_s),
      .rise_en(ren_q), .fall_en(fen_q),
      .clr_we(wr_en && sel_reg == REG_STAT), .clr_mask(wmask),
      .status(stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         ren_q <= '0;
         fen_q <= '0;
         alt_q <= '0;
      end else if (wr_en) begin
         unique case (sel_reg)
            REG_DIR: dir_q <= wmask;
            REG_SET: out_q <= out_q | wmask;
            REG_CLR: out_q <= out_q & ~wmask;
            REG_REN: ren_q <= wmask;
            REG_FEN: fen_q <= wmask;
            REG_ALT: alt_q <= wmask;
            default: ;
         endcase
      end
   end

   always_comb begin
      logic [NUM_PINS-1:0] v;
      unique case (sel_reg)
         REG_LEVEL: v = lvl_s;
         REG_DIR:   v = dir_q;
         REG_REN:   v = ren_q;
         REG_FEN:   v = fen_q;
         REG_STAT:  v = stat_q;
         REG_ALT:   v = alt_q;
         default:   v = '0;
      endcase
      bus_rdata = '0;
      if (bus_sel && !bus_wr) bus_rdata[NUM_PINS-1:0] = v;
   end

   assign pin_out    = out_q;
   assign pin_oe     = dir_q;
   assign alt_func   = alt_q;
   assign irq_direct = stat_q[NUM_DIRECT-1:0];
   assign irq_shared = |stat_q[NUM_PINS-1:NUM_DIRECT];
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
   parameter int NUM_PINS = 28,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] ren,
   input logic [NUM_PINS-1:0] fen
);
   logic                w_set, w_clr, w_stat;
   logic [NUM_PINS-1:0] wd;
   logic                unused_chk;

   assign unused_chk = ^{bus_wdata, bus_addr};
   assign wd     = bus_wdata[NUM_PINS-1:0];
   assign w_set  = bus_sel && bus_wr && bus_addr[4:2] == 3'd2;
   assign w_clr  = bus_sel && bus_wr && bus_addr[4:2] == 3'd3;
   assign w_stat = bus_sel && bus_wr && bus_addr[4:2] == 3'd6;

   AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      w_set |=> ((pin_out & $past(wd)) == $past(wd)));                      // R4
   AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr |=> ((pin_out & $past(wd)) == '0));                             // R5
   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_set || w_clr) |=> $stable(pin_out));                              // R4
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !w_stat |=> (($past(status) & ~status) == '0));                       // R9
   AST_NO_UNENABLED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~($past(ren) | $past(fen))) == '0)); // R7

   if (DATA_W > NUM_PINS) begin : g_hi
      AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rdata[DATA_W-1:NUM_PINS] == '0);                               // R2
   end
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pin_out(pin_out), .status(stat_q), .ren(ren_q), .fen(fen_q)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
   localparam int NP = 28;
   localparam int ND = 11;
   localparam logic [4:0] A_LVL = 5'h00, A_DIR = 5'h04, A_SET = 5'h08, A_CLR = 5'h0C,
                          A_REN = 5'h10, A_FEN = 5'h14, A_STA = 5'h18, A_ALT = 5'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, alt_func;
   logic [ND-1:0] irq_direct;
   logic          irq_shared;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_edge_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_func(alt_func),
      .irq_direct(irq_direct), .irq_shared(irq_shared)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic check_irqs(input string req, input int p, input bit exp);
      logic [31:0] ed, es;
      ed = (p < ND && exp) ? (32'd1 << p) : 32'd0;
      es = (p >= ND && exp) ? 32'd1 : 32'd0;
      check({req, " irq_direct"}, {21'd0, irq_direct}, ed);
      check({req, " irq_shared"}, {31'd0, irq_shared}, es);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_DIR, r); check("R1 dir", r, 0);
      rd(A_REN, r); check("R1 ren", r, 0);
      rd(A_FEN, r); check("R1 fen", r, 0);
      rd(A_STA, r); check("R1 status", r, 0);
      rd(A_ALT, r); check("R1 alt", r, 0);
      check("R1 pin_out", {4'd0, pin_out}, 0);
      check("R1 irqs", {20'd0, irq_shared, irq_direct}, 0);

      // R2 / R3 direction, upper bits, strobe registers read zero
      wr(A_DIR, 32'hFFFF_FFFF);
      rd(A_DIR, r); check("R2 upper bits zero", r, 32'h0FFF_FFFF);
      check("R3 pin_oe all", {4'd0, pin_oe}, 32'h0FFF_FFFF);
      wr(A_DIR, 32'h0A5A_5A5A);
      check("R3 pin_oe pattern", {4'd0, pin_oe}, 32'h0A5A_5A5A);
      wr(A_SET, 32'h0000_00F0);
      rd(A_SET, r); check("R2 set reads zero", r, 0);
      rd(A_CLR, r); check("R2 clr reads zero", r, 0);

      // R4 / R5 set and clear strobes
      wr(A_CLR, 32'hFFFF_FFFF);
      check("R5 clear all", {4'd0, pin_out}, 0);
      wr(A_SET, 32'h0000_0005);
      wr(A_SET, 32'h0800_0002);
      check("R4 set accumulates", {4'd0, pin_out}, 32'h0800_0007);
      wr(A_CLR, 32'h0000_0004);
      check("R5 clear partial", {4'd0, pin_out}, 32'h0800_0003);
      wr(A_CLR, 32'h0);
      check("R5 zero clear no effect", {4'd0, pin_out}, 32'h0800_0003);

      // R13 alternate function
      wr(A_ALT, 32'hF123_4567);
      rd(A_ALT, r); check("R13 alt readback", r, 32'h0123_4567);
      check("R13 alt port", {4'd0, alt_func}, 32'h0123_4567);

      // R6 level register latency
      pin_in = 28'h9C3_A5E1;
      @(negedge clk);
      rd(A_LVL, r); check("R6 level not after one clock", r, 0);
      @(negedge clk);
      rd(A_LVL, r); check("R6 level after two clocks", r, 32'h09C3_A5E1);
      // no enables: status stays clear (R7)
      pin_in = '0;
      repeat (4) @(negedge clk);
      rd(A_STA, r); check("R7 no enable no status", r, 0);

      // R7 R8 R11 R12 sweep: every pin, every enable combination
      for (int p = 0; p < NP; p++) begin
         for (int m = 0; m < 4; m++) begin
            logic [31:0] bit_p;
            bit_p = 32'd1 << p;
            wr(A_REN, m[0] ? bit_p : 32'd0);
            wr(A_FEN, m[1] ? bit_p : 32'd0);
            wr(A_STA, 32'hFFFF_FFFF);
            pin_in[p] = 1'b1;
            repeat (3) @(negedge clk);
            rd(A_STA, r); check($sformatf("R7 rise pin %0d mode %0d", p, m), r, m[0] ? bit_p : 0);
            check_irqs($sformatf("R11/R12 rise pin %0d (R11 R12)", p), p, m[0]);
            wr(A_STA, bit_p);
            rd(A_STA, r); check($sformatf("R9 clear pin %0d", p), r, 0);
            pin_in[p] = 1'b0;
            repeat (3) @(negedge clk);
            rd(A_STA, r); check($sformatf("R8 fall pin %0d mode %0d", p, m), r, m[1] ? bit_p : 0);
            check_irqs($sformatf("R12 fall pin %0d (R11 R12)", p), p, m[1]);
            wr(A_STA, bit_p);
         end
      end

      // R9 partial clear keeps other pending bits
      wr(A_REN, 32'h0000_1001);
      wr(A_FEN, 32'h0);
      wr(A_STA, 32'hFFFF_FFFF);
      pin_in = 28'h000_1001;
      repeat (3) @(negedge clk);
      rd(A_STA, r); check("R9 two pending", r, 32'h0000_1001);
      wr(A_STA, 32'h0000_0001);
      rd(A_STA, r); check("R9 zero bits stay", r, 32'h0000_1000);
      check("R12 shared held", {31'd0, irq_shared}, 1);
      repeat (5) @(negedge clk);
      rd(A_STA, r); check("R9 sticky over time", r, 32'h0000_1000);
      wr(A_STA, 32'hFFFF_FFFF);
      rd(A_STA, r); check("R9 clear all", r, 0);
      pin_in = '0;
      repeat (3) @(negedge clk);

      // R10 edge and clear on the same clock edge
      wr(A_REN, 32'h0000_0001);
      pin_in[0] = 1'b1;
      repeat (2) @(negedge clk);
      wr(A_STA, 32'h0000_0001);
      rd(A_STA, r); check("R10 edge beats clear", r, 32'h0000_0001);
      check("R10 irq held", {21'd0, irq_direct}, 32'h1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule